// File: doc/BRIEF.md
# Dual-Compare Interval Timer

This block is one 16-bit timer channel. A count register climbs by one on each timer event and is compared with one of two limit registers. When the next value reaches the limit in use, the count goes back to zero on that same edge. In single-limit mode the pin gives a one-clock low pulse on each wrap. In alternating mode the channel swaps to the other limit after every wrap, and the pin level shows which limit is in use. This turns the pin into a waveform whose high and low times are set by the two limits.

The channel is evaluated only in a service slot that comes once every four clocks. A control word picks the event source. The internal source advances once per slot. The external source advances once for each rising edge on a pin; that edge first passes through a two-flop synchronizer and an edge detector, and is then held until the next slot. Software reads and writes the count, both limits and the control word over a small register bus. The count can be written at any time, and a write wins over an increment that falls in the same cycle.

Top module: `dual_limit_timer`

## Requirements
- R1: After reset the count, both limits and the control word read 0 and `tmr_out_o` is high.
- R2: Register select `addr_i`: 0 count, 1 primary limit, 2 secondary limit, 3 control. A write is taken when `wr_en_i` is high at a rising edge. `rdata_o` shows the selected register in the same cycle. Control bit 0 is run, bit 1 is alternating mode and bit 2 is external source. Control bits 15:3 always read 0.
- R3: A phase counter restarts at reset release, and service edges are the 4th, 8th, 12th ... rising edges after that. With run set and the internal source selected, the count rises by exactly one on each service edge and is stable between them.
- R4: When the incremented value equals or exceeds the active limit, the count becomes 0 on that edge, so a nonzero limit value is never read back from the count.
- R5: A limit value of 0 acts as 65536: the count passes 16'hFFFF and then wraps to 0.
- R6: In single-limit mode `tmr_out_o` is low for exactly the one clock after a wrap and high otherwise.
- R7: In alternating mode each wrap swaps the active limit, starting with the primary limit. `tmr_out_o` is high while the primary limit is active and low while the secondary limit is active. Clearing alternating mode returns the channel to the primary limit.
- R8: A count write on a service edge wins over the increment. The written value is read back, and the next slot adds one to it.
- R9: With the external source selected, each rising edge of `ext_evt_i` adds exactly one to the count, and the count shows it within six clocks. A level held high adds nothing more.
- R10: With run clear the count does not change. External edges seen while run is clear are dropped and are not counted after run is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 2 | Register select |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the selected register |
| ext_evt_i | input | 1 | Asynchronous external event input |
| tmr_out_o | output | 1 | Timer output pin |

## Verification
Two things can land on the same edge: a software write to the count and the slot increment. The bench follows the slot phase from reset release, so it can place a count write in the cycle just before a service edge. It then checks that the written value, and not the value plus one, is read back, and that the following slot adds exactly one. A second overlap comes from control writes landing on a service edge. The bench checks that the first increment appears only one slot later.

// File: rtl/dlt_pkg.sv
package dlt_pkg;

    typedef enum logic [1:0] {
        SEL_COUNT = 2'd0,
        SEL_LIM_A = 2'd1,
        SEL_LIM_B = 2'd2,
        SEL_CTRL  = 2'd3
    } reg_sel_e;

    // bit 2 external source, bit 1 alternating mode, bit 0 run
    typedef struct packed {
        logic ext_src;
        logic alt_mode;
        logic run;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/dlt_slot_gen.sv
module dlt_slot_gen #(
    parameter int unsigned SLOT_N = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic slot_o
);
    localparam int unsigned PH_W = (SLOT_N > 1) ? $clog2(SLOT_N) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_N - 1);

    logic [PH_W-1:0] ph_d, ph_q;

    always_comb begin
        ph_d = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) ph_q <= '0;
        else         ph_q <= ph_d;
    end

    assign slot_o = (ph_q == PH_LAST);
endmodule

// File: rtl/dlt_evt_sync.sv
module dlt_evt_sync #(
    parameter int unsigned SYNC_N = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic evt_i,
    input  logic slot_i,
    output logic evt_o
);
    typedef struct packed {
        logic [SYNC_N-1:0] sync;
        logic              last;
        logic              pend;
    } evt_state_t;

    evt_state_t s_d, s_q;
    logic       rise;

    assign rise = s_q.sync[SYNC_N-1] & ~s_q.last;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[SYNC_N-2:0], evt_i};
        s_d.last = s_q.sync[SYNC_N-1];
        // a held edge is consumed by the next slot, counted or not
        s_d.pend = slot_i ? 1'b0 : (s_q.pend | rise);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign evt_o = rise | s_q.pend;
endmodule

// File: rtl/dlt_count_core.sv
module dlt_count_core #(
    parameter int unsigned CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] lim_a_i,
    input  logic [CNT_W-1:0] lim_b_i,
    input  logic             sel_b_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             term_o
);
    logic [CNT_W-1:0] lim;
    logic [CNT_W:0]   lim_x;
    logic [CNT_W:0]   inc;

    always_comb begin
        lim    = sel_b_i ? lim_b_i : lim_a_i;
        lim_x  = (lim == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, lim};
        inc    = {1'b0, cnt_i} + 1'b1;
        term_o = (inc >= lim_x);
        cnt_o  = term_o ? '0 : inc[CNT_W-1:0];
    end
endmodule

// File: rtl/dual_limit_timer.sv
module dual_limit_timer #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned SLOT_N = 4,
    parameter int unsigned SYNC_N = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       addr_i,
    input  logic             wr_en_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] rdata_o,
    input  logic             ext_evt_i,
    output logic             tmr_out_o
);
    import dlt_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim_a;
        logic [CNT_W-1:0] lim_b;
        ctrl_t            ctrl;
        logic             sel_b;
        logic             pulse;
    } tmr_state_t;

    tmr_state_t       s_d, s_q;
    logic             slot;
    logic             evt;
    logic             tick;
    logic [CNT_W-1:0] cnt_nxt;
    logic             term;
    reg_sel_e         sel;

    assign sel = reg_sel_e'(addr_i);

    dlt_slot_gen #(.SLOT_N(SLOT_N)) u_slot (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .slot_o(slot)
    );

    dlt_evt_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .evt_i (ext_evt_i),
        .slot_i(slot),
        .evt_o (evt)
    );

    dlt_count_core #(.CNT_W(CNT_W)) u_core (
        .cnt_i  (s_q.cnt),
        .lim_a_i(s_q.lim_a),
        .lim_b_i(s_q.lim_b),
        .sel_b_i(s_q.sel_b),
        .cnt_o  (cnt_nxt),
        .term_o (term)
    );

    assign tick = s_q.ctrl.run & slot & (s_q.ctrl.ext_src ? evt : 1'b1);

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        if (tick) begin
            s_d.cnt   = cnt_nxt;
            s_d.pulse = term;
            if (term && s_q.ctrl.alt_mode) s_d.sel_b = ~s_q.sel_b;
        end
        if (!s_q.ctrl.alt_mode) s_d.sel_b = 1'b0;
        if (wr_en_i) begin
            unique case (sel)
                SEL_COUNT: s_d.cnt   = wdata_i;
                SEL_LIM_A: s_d.lim_a = wdata_i;
                SEL_LIM_B: s_d.lim_b = wdata_i;
                SEL_CTRL:  s_d.ctrl  = ctrl_t'(wdata_i[CTRL_W-1:0]);
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    always_comb begin
        unique case (sel)
            SEL_COUNT: rdata_o = s_q.cnt;
            SEL_LIM_A: rdata_o = s_q.lim_a;
            SEL_LIM_B: rdata_o = s_q.lim_b;
            SEL_CTRL:  rdata_o = CNT_W'(s_q.ctrl);
            default:   rdata_o = '0;
        endcase
    end

    assign tmr_out_o = s_q.ctrl.alt_mode ? ~s_q.sel_b : ~s_q.pulse;

    // state views for the bound checker
    logic [CNT_W-1:0] cnt_w, lim_a_w, lim_b_w;
    logic             alt_w, run_w, ext_w, sel_b_w;
    assign cnt_w   = s_q.cnt;
    assign lim_a_w = s_q.lim_a;
    assign lim_b_w = s_q.lim_b;
    assign alt_w   = s_q.ctrl.alt_mode;
    assign run_w   = s_q.ctrl.run;
    assign ext_w   = s_q.ctrl.ext_src;
    assign sel_b_w = s_q.sel_b;
endmodule

// File: rtl/dlt_chk.sv
module dlt_chk #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned SLOT_N = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [1:0]       addr_i,
    input logic             wr_en_i,
    input logic [CNT_W-1:0] wdata_i,
    input logic [CNT_W-1:0] rdata_o,
    input logic             tmr_out_o,
    input logic [CNT_W-1:0] cnt_i,
    input logic [CNT_W-1:0] lim_a_i,
    input logic [CNT_W-1:0] lim_b_i,
    input logic             alt_i,
    input logic             run_i,
    input logic             ext_i,
    input logic             sel_b_i
);
    localparam int unsigned PH_W = (SLOT_N > 1) ? $clog2(SLOT_N) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_N - 1);

    logic [PH_W-1:0] ph_q;
    always_ff @(posedge clk_i) begin
        if (!rst_ni)              ph_q <= '0;
        else if (ph_q == PH_LAST) ph_q <= '0;
        else                      ph_q <= ph_q + 1'b1;
    end

    logic           cnt_wr, ctl_wr;
    logic [CNT_W:0] lim_x;
    assign cnt_wr = wr_en_i && (addr_i == 2'd0);
    assign ctl_wr = wr_en_i && (addr_i == 2'd3);
    assign lim_x  = ((sel_b_i ? lim_b_i : lim_a_i) == '0) ? {1'b1, {CNT_W{1'b0}}}
                  : {1'b0, (sel_b_i ? lim_b_i : lim_a_i)};

    // R3
    cnt_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cnt_wr && ph_q != PH_LAST) |=> $stable(cnt_i));

    // R4
    wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !ext_i && ph_q == PH_LAST && !cnt_wr && ({1'b0, cnt_i} + 1'b1 == lim_x))
        |=> (cnt_i == '0));

    // R8
    wr_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_wr |=> (cnt_i == $past(wdata_i)));

    // R6
    pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!alt_i && !tmr_out_o) |=> (alt_i || tmr_out_o));

    // R7
    alt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alt_i && ph_q != PH_LAST && !ctl_wr) |=> $stable(tmr_out_o));

    // R2
    ctrl_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == 2'd3) |-> (rdata_o[CNT_W-1:dlt_pkg::CTRL_W] == '0));
endmodule

bind dual_limit_timer dlt_chk #(.CNT_W(CNT_W), .SLOT_N(SLOT_N)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .tmr_out_o(tmr_out_o),
    .cnt_i    (cnt_w),
    .lim_a_i  (lim_a_w),
    .lim_b_i  (lim_b_w),
    .alt_i    (alt_w),
    .run_i    (run_w),
    .ext_i    (ext_w),
    .sel_b_i  (sel_b_w)
);

// File: tb/dual_limit_timer_tb.sv
`timescale 1ns/1ps
module dual_limit_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ext_evt = 1'b0;
    logic        tout;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    dual_limit_timer u_dut (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .addr_i   (addr),
        .wr_en_i  (wr_en),
        .wdata_i  (wdata),
        .rdata_o  (rdata),
        .ext_evt_i(ext_evt),
        .tmr_out_o(tout)
    );

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (cyc %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_phase(input int p);
        while (cyc % 4 != p) @(negedge clk);
    endtask

    task automatic goto_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reset register", v, 16'h0000);
        end
        chk("R1 reset pin", {15'd0, tout}, 16'h0001);
    endtask

    task automatic t_regs();
        logic [15:0] v;
        wr(2'd1, 16'hA5A5);
        wr(2'd2, 16'h5A5A);
        wr(2'd3, 16'hFFF8);
        rd(2'd1, v); chk("R2 primary readback", v, 16'hA5A5);
        rd(2'd2, v); chk("R2 secondary readback", v, 16'h5A5A);
        rd(2'd3, v); chk("R2 control pad bits", v, 16'h0000);
        wr(2'd0, 16'h0005);
        repeat (12) @(negedge clk);
        rd(2'd0, v); chk("R10 stopped count", v, 16'h0005);
    endtask

    task automatic t_single();
        logic [15:0] v;
        int c;
        wr(2'd3, 16'h0000);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0003);
        wait_phase(3);
        c = cyc;
        wr(2'd3, 16'h0001);
        for (int k = 1; k <= 16; k++) begin
            int n;
            goto_cyc(c + k);
            n = (k - 1) / 4;
            rd(2'd0, v);
            chk("R3 R4 single count", v, 16'(n % 3));
            chk("R6 single pin", {15'd0, tout},
                ((k - 1) % 4 == 0 && n > 0 && n % 3 == 0) ? 16'h0000 : 16'h0001);
        end
    endtask

    task automatic t_alt();
        logic [15:0] v;
        int c;
        int mc;
        int ma;
        wr(2'd3, 16'h0000);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0002);
        wr(2'd2, 16'h0003);
        wait_phase(3);
        c = cyc;
        wr(2'd3, 16'h0003);
        mc = 0;
        ma = 0;
        chk("R7 start on primary", {15'd0, tout}, 16'h0001);
        for (int s = 1; s <= 12; s++) begin
            mc = mc + 1;
            if (mc >= (ma ? 3 : 2)) begin
                mc = 0;
                ma = 1 - ma;
            end
            goto_cyc(c + 1 + 4 * s);
            rd(2'd0, v);
            chk("R7 alt count", v, 16'(mc));
            chk("R7 alt pin", {15'd0, tout}, ma ? 16'h0000 : 16'h0001);
        end
        wr(2'd3, 16'h0001);
        @(negedge clk);
        chk("R7 back to primary", {15'd0, tout}, 16'h0001);
    endtask

    task automatic t_big_and_prio();
        logic [15:0] v;
        int c;
        wr(2'd3, 16'h0000);
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'hFFFE);
        wait_phase(3);
        c = cyc;
        wr(2'd3, 16'h0001);
        goto_cyc(c + 5);
        rd(2'd0, v); chk("R5 reaches FFFF", v, 16'hFFFF);
        goto_cyc(c + 9);
        rd(2'd0, v); chk("R5 wraps after FFFF", v, 16'h0000);
        chk("R5 R6 wrap pulse", {15'd0, tout}, 16'h0000);
        goto_cyc(c + 10);
        chk("R6 pulse ends", {15'd0, tout}, 16'h0001);
        wait_phase(3);
        c = cyc;
        wr(2'd0, 16'h1234);
        rd(2'd0, v); chk("R8 write beats increment", v, 16'h1234);
        goto_cyc(c + 5);
        rd(2'd0, v); chk("R8 next slot adds one", v, 16'h1235);
    endtask

    task automatic t_ext();
        logic [15:0] v;
        int c;
        wr(2'd3, 16'h0000);
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'h0000);
        wr(2'd3, 16'h0005);
        wait_phase(0);
        c = cyc;
        ext_evt = 1'b1;
        goto_cyc(c + 2);
        rd(2'd0, v); chk("R9 synchronizer delay", v, 16'h0000);
        goto_cyc(c + 6);
        rd(2'd0, v); chk("R9 edge counted", v, 16'h0001);
        repeat (20) @(negedge clk);
        rd(2'd0, v); chk("R9 held level ignored", v, 16'h0001);
        ext_evt = 1'b0;
        repeat (4) @(negedge clk);
        wait_phase(2);
        c = cyc;
        ext_evt = 1'b1;
        @(negedge clk);
        ext_evt = 1'b0;
        goto_cyc(c + 6);
        rd(2'd0, v); chk("R9 second edge", v, 16'h0002);
        wr(2'd3, 16'h0004);
        ext_evt = 1'b1;
        repeat (2) @(negedge clk);
        ext_evt = 1'b0;
        repeat (10) @(negedge clk);
        wr(2'd3, 16'h0005);
        repeat (12) @(negedge clk);
        rd(2'd0, v); chk("R10 edge while stopped dropped", v, 16'h0002);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_single();
        t_alt();
        t_big_and_prio();
        t_ext();
        summary();
        $finish;
    end
endmodule